// File: doc/BRIEF.md
# TCM and System SRAM Address Router

This block sits between a processor's access path and a single on-chip SRAM pool that serves three purposes at once: instruction tightly coupled memory (ITCM), data tightly coupled memory (DTCM), and general system SRAM. Each access arrives with its address and a flag that marks it as an instruction fetch or a data access. One clock cycle later, the router presents three results: the target that must serve the access (ITCM, DTCM, system SRAM, boot memory or flash), the physical byte offset inside the SRAM pool, and an out-of-range flag for system SRAM addresses that fall past the usable part of the pool.

The two TCMs always have the same size, which is fixed when the block is built to 32, 64 or 128 KB. In the physical pool, ITCM takes the lowest part, DTCM takes the part above it, and system SRAM gets whatever is left. A single enable bit, written through a one-bit write port and cleared by reset, switches TCM routing on or off. While the bit is clear, the low instruction region falls through to boot memory, and the whole pool is reachable as system SRAM. While the bit is set, the bottom of that low region comes from ITCM, the DTCM window becomes live, and the system SRAM window shrinks to the memory that remains after the TCMs.

With the default parameters (TCM 128 KB, pool 384 KB), the address windows are as follows. The low region is 0x0000_0000 to 0x003F_FFFF. The DTCM window starts at 0x2000_0000. The system SRAM window starts at 0x2040_0000 and is 1 MB wide. Every other address belongs to flash.

Top module: `tcm_sram_router`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `rsp_valid`=0, `rsp_target`=0 (none), `rsp_offset`=0 and `rsp_oor`=0, and the TCM enable bit is cleared. After reset, a fetch at address 0x1000 therefore goes to boot memory.
- R2: An access sampled with `acc_valid`=1 on a rising edge is reported on the outputs from that edge until the next one. When `acc_valid`=0, the next cycle shows `rsp_valid`=0, target 0, offset 0 and oor 0.
- R3: When TCM is disabled, an instruction access inside the low region goes to boot memory (target code 4) with offset 0.
- R4: When TCM is enabled, an instruction access below the TCM size goes to ITCM (code 1) with offset equal to the address.
- R5: When TCM is enabled, an instruction access in the low region at or above the TCM size goes to flash (code 5) with offset 0.
- R6: When TCM is enabled, a data access inside the DTCM window goes to DTCM (code 2) with offset equal to TCM size plus the distance from the window base. When TCM is disabled, that window goes to flash.
- R7: When TCM is enabled, an access in the system SRAM window whose distance from the base is below pool − 2×TCM size goes to system SRAM (code 3) with offset 2×TCM size plus that distance. Instruction and data accesses behave the same way here.
- R8: When TCM is disabled, the system SRAM window maps onto the whole pool, with offset equal to the distance from the base for any distance below the pool size.
- R9: An access in the system SRAM window at or beyond the currently usable size returns code 3 with `rsp_oor`=1 and offset 0. Every other response has `rsp_oor`=0.
- R10: A write with `reg_we`=1 loads `reg_wdata` into the enable bit at the clock edge. An access sampled at that same edge is still routed with the old value, and the new value applies from the following edge on.
- R11: A data access in the low region goes to boot memory. Any access outside the low region, the live DTCM window and the system SRAM window goes to flash. Both of these report offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the TCM enable bit |
| reg_wdata | input | 1 | Value written to the TCM enable bit |
| acc_valid | input | 1 | Access present this cycle |
| acc_is_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| acc_addr | input | ADDR_W | Access address |
| rsp_valid | output | 1 | Registered result valid |
| rsp_target | output | 3 | 0 none, 1 ITCM, 2 DTCM, 3 system SRAM, 4 boot, 5 flash |
| rsp_offset | output | OFF_W | Physical byte offset in the SRAM pool |
| rsp_oor | output | 1 | System SRAM access beyond the usable size |

## Verification
A write to the enable bit and an access can arrive in the same cycle. The router must then route the access with the enable value from before the write, and the new value must take effect for the next access. The bench makes this happen by driving the write and a fetch at address 0x1000 together, once to switch routing on and once to switch it off. After each pair, it repeats the fetch alone. The first response must still show the old target (boot memory, or ITCM), and the repeated fetch must show the new one.

// File: rtl/sram_route_pkg.sv
package sram_route_pkg;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_ITCM  = 3'd1,
    TGT_DTCM  = 3'd2,
    TGT_SYS   = 3'd3,
    TGT_BOOT  = 3'd4,
    TGT_FLASH = 3'd5
  } route_tgt_e;

endpackage

// File: rtl/tcm_enable_reg.sv
module tcm_enable_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic tcm_on
);

  // Enable bit: cleared by reset so fetches start from boot memory.
  always_ff @(posedge clk) begin
    if (rst) begin
      tcm_on <= 1'b0;
    end else if (wr_en) begin
      tcm_on <= wr_bit;
    end
  end

endmodule

// File: rtl/route_region_match.sv
module route_region_match #(
  parameter int          ADDR_W    = 32,
  parameter int unsigned TCM_BYTES = 131072,
  parameter int unsigned LOW_BYTES = 32'h0040_0000,
  parameter int unsigned DTCM_BASE = 32'h2000_0000,
  parameter int unsigned SRAM_BASE = 32'h2040_0000,
  parameter int unsigned SRAM_WIN  = 32'h0010_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_low,
  output logic              hit_itcm,
  output logic              hit_dtcm,
  output logic              hit_win,
  output logic [ADDR_W-1:0] dtcm_rel,
  output logic [ADDR_W-1:0] win_rel
);

  localparam logic [ADDR_W-1:0] TCM_A  = ADDR_W'(TCM_BYTES);
  localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_BYTES);
  localparam logic [ADDR_W-1:0] DTCM_A = ADDR_W'(DTCM_BASE);
  localparam logic [ADDR_W-1:0] SYS_A  = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(SRAM_WIN);

  always_comb begin
    dtcm_rel = addr - DTCM_A;
    win_rel  = addr - SYS_A;
    hit_low  = (addr < LOW_A);
    hit_itcm = (addr < TCM_A);
    hit_dtcm = (addr >= DTCM_A) && (dtcm_rel < TCM_A);
    hit_win  = (addr >= SYS_A) && (win_rel < WIN_A);
  end

endmodule

// File: rtl/sram_pool_mapper.sv
module sram_pool_mapper #(
  parameter int          ADDR_W     = 32,
  parameter int unsigned TCM_BYTES  = 131072,
  parameter int unsigned POOL_BYTES = 393216,
  parameter int          OFF_W      = 19
) (
  input  logic              tcm_on,
  input  logic [ADDR_W-1:0] win_rel,
  output logic [OFF_W-1:0]  sys_off,
  output logic              sys_oor
);

  localparam logic [ADDR_W-1:0] FULL_LIM  = ADDR_W'(POOL_BYTES);
  localparam logic [ADDR_W-1:0] SPLIT_LIM = ADDR_W'(POOL_BYTES - 2 * TCM_BYTES);
  localparam logic [OFF_W-1:0]  SYS_BASE  = OFF_W'(2 * TCM_BYTES);

  logic [ADDR_W-1:0] limit;

  always_comb begin
    limit   = tcm_on ? SPLIT_LIM : FULL_LIM;
    sys_oor = (win_rel >= limit);
    if (sys_oor) begin
      sys_off = '0;
    end else if (tcm_on) begin
      sys_off = SYS_BASE + win_rel[OFF_W-1:0];
    end else begin
      sys_off = win_rel[OFF_W-1:0];
    end
  end

endmodule

// File: rtl/route_select.sv
module route_select
  import sram_route_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int unsigned TCM_BYTES = 131072,
  parameter int          OFF_W     = 19
) (
  input  logic              is_instr,
  input  logic              tcm_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit_low,
  input  logic              hit_itcm,
  input  logic              hit_dtcm,
  input  logic              hit_win,
  input  logic [ADDR_W-1:0] dtcm_rel,
  input  logic [OFF_W-1:0]  sys_off,
  input  logic              sys_oor,
  output route_tgt_e        tgt,
  output logic [OFF_W-1:0]  off,
  output logic              oor
);

  localparam logic [OFF_W-1:0] DTCM_PHYS = OFF_W'(TCM_BYTES);

  always_comb begin
    tgt = TGT_FLASH;
    off = '0;
    oor = 1'b0;
    if (hit_low) begin
      if (is_instr && tcm_on) begin
        if (hit_itcm) begin
          tgt = TGT_ITCM;
          off = addr[OFF_W-1:0];
        end else begin
          tgt = TGT_FLASH;
        end
      end else begin
        tgt = TGT_BOOT;
      end
    end else if (!is_instr && tcm_on && hit_dtcm) begin
      tgt = TGT_DTCM;
      off = DTCM_PHYS + dtcm_rel[OFF_W-1:0];
    end else if (hit_win) begin
      tgt = TGT_SYS;
      off = sys_off;
      oor = sys_oor;
    end
  end

endmodule

// File: rtl/tcm_sram_router.sv
module tcm_sram_router
  import sram_route_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int unsigned TCM_KB    = 128,
  parameter int unsigned POOL_KB   = 384,
  parameter int unsigned LOW_BYTES = 32'h0040_0000,
  parameter int unsigned DTCM_BASE = 32'h2000_0000,
  parameter int unsigned SRAM_BASE = 32'h2040_0000,
  parameter int unsigned SRAM_WIN  = 32'h0010_0000,
  localparam int unsigned TCM_BYTES  = TCM_KB * 1024,
  localparam int unsigned POOL_BYTES = POOL_KB * 1024,
  localparam int          OFF_W      = $clog2(POOL_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_wdata,
  input  logic              acc_valid,
  input  logic              acc_is_instr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_target,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic              rsp_oor
);

  logic              tcm_en;
  logic              hit_low, hit_itcm, hit_dtcm, hit_win;
  logic [ADDR_W-1:0] dtcm_rel, win_rel;
  logic [OFF_W-1:0]  sys_off, nxt_off;
  logic              sys_oor, nxt_oor;
  route_tgt_e        nxt_tgt;

  tcm_enable_reg u_en (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_we),
    .wr_bit (reg_wdata),
    .tcm_on (tcm_en)
  );

  route_region_match #(
    .ADDR_W    (ADDR_W),
    .TCM_BYTES (TCM_BYTES),
    .LOW_BYTES (LOW_BYTES),
    .DTCM_BASE (DTCM_BASE),
    .SRAM_BASE (SRAM_BASE),
    .SRAM_WIN  (SRAM_WIN)
  ) u_match (
    .addr     (acc_addr),
    .hit_low  (hit_low),
    .hit_itcm (hit_itcm),
    .hit_dtcm (hit_dtcm),
    .hit_win  (hit_win),
    .dtcm_rel (dtcm_rel),
    .win_rel  (win_rel)
  );

  sram_pool_mapper #(
    .ADDR_W     (ADDR_W),
    .TCM_BYTES  (TCM_BYTES),
    .POOL_BYTES (POOL_BYTES),
    .OFF_W      (OFF_W)
  ) u_map (
    .tcm_on  (tcm_en),
    .win_rel (win_rel),
    .sys_off (sys_off),
    .sys_oor (sys_oor)
  );

  route_select #(
    .ADDR_W    (ADDR_W),
    .TCM_BYTES (TCM_BYTES),
    .OFF_W     (OFF_W)
  ) u_sel (
    .is_instr (acc_is_instr),
    .tcm_on   (tcm_en),
    .addr     (acc_addr),
    .hit_low  (hit_low),
    .hit_itcm (hit_itcm),
    .hit_dtcm (hit_dtcm),
    .hit_win  (hit_win),
    .dtcm_rel (dtcm_rel),
    .sys_off  (sys_off),
    .sys_oor  (sys_oor),
    .tgt      (nxt_tgt),
    .off      (nxt_off),
    .oor      (nxt_oor)
  );

  // Registered result stage; idle cycles drive all-zero outputs.
  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      rsp_valid  <= 1'b0;
      rsp_target <= TGT_NONE;
      rsp_offset <= '0;
      rsp_oor    <= 1'b0;
    end else begin
      rsp_valid  <= 1'b1;
      rsp_target <= nxt_tgt;
      rsp_offset <= nxt_off;
      rsp_oor    <= nxt_oor;
    end
  end

endmodule

// File: rtl/tcm_sram_router_chk.sv
module tcm_sram_router_chk #(
  parameter int unsigned TCM_BYTES  = 131072,
  parameter int unsigned POOL_BYTES = 393216,
  parameter int          OFF_W      = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             reg_wdata,
  input logic             acc_valid,
  input logic             acc_is_instr,
  input logic             tcm_en,
  input logic             rsp_valid,
  input logic [2:0]       rsp_target,
  input logic [OFF_W-1:0] rsp_offset,
  input logic             rsp_oor
);

  localparam logic [OFF_W:0] TCM_LIM  = (OFF_W + 1)'(TCM_BYTES);
  localparam logic [OFF_W:0] POOL_LIM = (OFF_W + 1)'(POOL_BYTES);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_target == 3'd0 && !rsp_oor && !tcm_en)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && rsp_target == 3'd0)); // R2

  AST_ITCM_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd1) |-> ($past(acc_is_instr) && $past(tcm_en))); // R4

  AST_ITCM_OFF_BOUND: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd1) |-> ({1'b0, rsp_offset} < TCM_LIM)); // R4

  AST_DTCM_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd2) |-> (!$past(acc_is_instr) && $past(tcm_en))); // R6

  AST_OFF_IN_POOL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ({1'b0, rsp_offset} < POOL_LIM)); // R8

  AST_OOR_ONLY_SYS: assert property (@(posedge clk) disable iff (rst)
    rsp_oor |-> (rsp_target == 3'd3 && rsp_offset == '0)); // R9

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (tcm_en == $past(reg_wdata))); // R10

endmodule

bind tcm_sram_router tcm_sram_router_chk #(
  .TCM_BYTES  (TCM_BYTES),
  .POOL_BYTES (POOL_BYTES),
  .OFF_W      (OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_we       (reg_we),
  .reg_wdata    (reg_wdata),
  .acc_valid    (acc_valid),
  .acc_is_instr (acc_is_instr),
  .tcm_en       (tcm_en),
  .rsp_valid    (rsp_valid),
  .rsp_target   (rsp_target),
  .rsp_offset   (rsp_offset),
  .rsp_oor      (rsp_oor)
);

// File: tb/tcm_sram_router_tb.sv
module tcm_sram_router_tb;

  localparam int OFF_W = 19;
  localparam int VW    = 1 + 1 + 32 + 3 + OFF_W + 1 + 8;
  localparam int NV    = 20;

  // {en, instr, addr, exp_target, exp_offset, exp_oor, req}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 1'b1, 32'h0000_1000, 3'd4, 19'h00000, 1'b0, 8'd3},  // R3
    {1'b0, 1'b1, 32'h003F_FFFC, 3'd4, 19'h00000, 1'b0, 8'd3},  // R3
    {1'b0, 1'b1, 32'h0040_0000, 3'd5, 19'h00000, 1'b0, 8'd11}, // R11
    {1'b1, 1'b1, 32'h0000_1000, 3'd1, 19'h01000, 1'b0, 8'd4},  // R4
    {1'b1, 1'b1, 32'h0001_FFFC, 3'd1, 19'h1FFFC, 1'b0, 8'd4},  // R4
    {1'b1, 1'b1, 32'h0002_0000, 3'd5, 19'h00000, 1'b0, 8'd5},  // R5
    {1'b1, 1'b0, 32'h2000_0010, 3'd2, 19'h20010, 1'b0, 8'd6},  // R6
    {1'b1, 1'b0, 32'h2001_FFFC, 3'd2, 19'h3FFFC, 1'b0, 8'd6},  // R6
    {1'b1, 1'b0, 32'h2002_0000, 3'd5, 19'h00000, 1'b0, 8'd6},  // R6
    {1'b0, 1'b0, 32'h2000_0010, 3'd5, 19'h00000, 1'b0, 8'd6},  // R6
    {1'b1, 1'b0, 32'h2040_0000, 3'd3, 19'h40000, 1'b0, 8'd7},  // R7
    {1'b1, 1'b0, 32'h2041_FFFC, 3'd3, 19'h5FFFC, 1'b0, 8'd7},  // R7
    {1'b1, 1'b1, 32'h2040_0004, 3'd3, 19'h40004, 1'b0, 8'd7},  // R7
    {1'b1, 1'b0, 32'h2042_0000, 3'd3, 19'h00000, 1'b1, 8'd9},  // R9
    {1'b0, 1'b0, 32'h2042_0000, 3'd3, 19'h20000, 1'b0, 8'd8},  // R8
    {1'b0, 1'b0, 32'h2045_FFFC, 3'd3, 19'h5FFFC, 1'b0, 8'd8},  // R8
    {1'b0, 1'b0, 32'h2046_0000, 3'd3, 19'h00000, 1'b1, 8'd9},  // R9
    {1'b0, 1'b0, 32'h0000_0100, 3'd4, 19'h00000, 1'b0, 8'd11}, // R11
    {1'b1, 1'b0, 32'h0000_0100, 3'd4, 19'h00000, 1'b0, 8'd11}, // R11
    {1'b1, 1'b0, 32'h8000_0000, 3'd5, 19'h00000, 1'b0, 8'd11}  // R11
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic             reg_wdata = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_is_instr = 1'b0;
  logic [31:0]      acc_addr = '0;
  logic             rsp_valid;
  logic [2:0]       rsp_target;
  logic [OFF_W-1:0] rsp_offset;
  logic             rsp_oor;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  logic cur_en  = 1'b0;

  always #4 clk = ~clk;

  tcm_sram_router u_dut (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .acc_valid    (acc_valid),
    .acc_is_instr (acc_is_instr),
    .acc_addr     (acc_addr),
    .rsp_valid    (rsp_valid),
    .rsp_target   (rsp_target),
    .rsp_offset   (rsp_offset),
    .rsp_oor      (rsp_oor)
  );

  task automatic check_rsp(input int req, input logic v, input logic [2:0] t,
                           input logic [OFF_W-1:0] o, input logic r);
    n_checks++;
    if (rsp_valid !== v || rsp_target !== t || rsp_offset !== o || rsp_oor !== r) begin
      n_fails++;
      $display("FAIL R%0d: actual v=%0b t=%0d off=%h oor=%0b expected v=%0b t=%0d off=%h oor=%0b",
               req, rsp_valid, rsp_target, rsp_offset, rsp_oor, v, t, o, r);
    end
  endtask

  // Drive one cycle at a falling edge; result is visible at the next falling edge.
  task automatic drive(input logic we, input logic wd, input logic av,
                       input logic ins, input logic [31:0] a);
    reg_we       = we;
    reg_wdata    = wd;
    acc_valid    = av;
    acc_is_instr = ins;
    acc_addr     = a;
    @(negedge clk);
    reg_we    = 1'b0;
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_rsp(1, 1'b0, 3'd0, '0, 1'b0);                    // R1 reset state
    drive(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(1, 1'b1, 3'd4, '0, 1'b0);                    // R1 enable cleared
    drive(1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_1000);
    check_rsp(2, 1'b0, 3'd0, '0, 1'b0);                    // R2 idle

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      if (v[VW-1] !== cur_en) begin
        drive(1'b1, v[VW-1], 1'b0, 1'b0, '0);
        cur_en = v[VW-1];
      end
      drive(1'b0, 1'b0, 1'b1, v[VW-2], v[VW-3 -: 32]);
      check_rsp(int'(v[7:0]), 1'b1, v[VW-35 -: 3], v[OFF_W+8 : 9], v[8]);
    end

    // R10: write and access in the same cycle
    drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(10, 1'b1, 3'd4, '0, 1'b0);                   // R10 old value
    drive(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(10, 1'b1, 3'd1, 19'h01000, 1'b0);            // R10 new value
    drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(10, 1'b1, 3'd1, 19'h01000, 1'b0);            // R10 old value
    drive(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(10, 1'b1, 3'd4, '0, 1'b0);                   // R10 new value

    // R1: reset in mid-run clears the enable bit
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    check_rsp(1, 1'b1, 3'd4, '0, 1'b0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2: watchdog actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule